// File: doc/BRIEF.md
# SCCB Single-Byte Register Master

This block drives a two-wire camera-control bus as its only master. It moves one byte to or from one register of an attached device per command. Software programs the device's 7-bit identity, an 8-bit register index and, for a write, a data byte. It then sets the go bit. The block refuses the command while its own transfer is still active. Otherwise it builds the whole frame by itself, ends it with a stop condition and reports completion.

A write is one frame: identity with the write bit, then register index, then data. A read is two frames. The first is a write frame that carries only the identity and register index. After a stop and an idle gap comes a second frame: identity with the read bit, then eight data bits from the device, with the master leaving SDA high on the ninth bit. The acknowledge slot of every byte is not checked. Five sticky flags report progress: done, read byte present, write byte wanted, write-byte underflow and read-byte overwrite. Each flag has an interrupt enable, and a vector register reports the most urgent enabled flag.

The register port has no back-pressure. Every write is taken in the cycle it is presented, and read data is combinational from the address. The bus pins are open-drain enables: a 1 pulls the line low, and a 0 releases it to its pull-up. One bus quarter-bit lasts DIV clock cycles.

Top module: `sccb_master`

## Requirements
- R1: After reset, STATUS (address 5) reads 0x00, VECTOR (address 7) reads 0, `irq` is 0 and both `scl_oe` and `sda_oe` are 0.
- R2: A write command (CTRL at address 0 written with bit0 = go and bit1 = 1 for write) produces one START, then the bytes {ID,0}, index and data, each sent MSB first with a ninth released clock, then one STOP. ID is at address 1, the index at address 2 and the data byte at address 3.
- R3: A read command (bit1 = 0) produces START, {ID,0}, index, STOP, then START, {ID,1}, eight sampled bits and a ninth bit with SDA released, then STOP. The byte is readable at RXDATA (address 4).
- R4: A go command written while STATUS bit7 (busy) is 1 is ignored. No extra frame or START appears.
- R5: Busy (STATUS bit7) is 1 from the go command until the final STOP completes. While busy is 0, both bus enables are 0.
- R6: CTRL bit2, the stop request, has no effect at any time. A transfer in progress still completes in full.
- R7: Flag bit0 (done) sets when a transfer finishes.
- R8: Flag bit1 (read byte present) sets when a read byte is stored. If bit1 is already set at that moment, flag bit4 (overwrite) also sets.
- R9: Flag bit2 (write byte wanted) sets when a write is launched while the data register is empty. The data register is filled by writing address 3 and emptied when the engine takes it. If the data phase starts while the register is empty, flag bit3 (underflow) sets and 0xFF is sent.
- R10: Flags are cleared by writing 1 to their bit of STATUS. Writing 0 leaves a flag unchanged.
- R11: `irq` is 1 when any flag is set with its enable bit set in IRQEN (address 6, same bit positions). VECTOR gives the highest-priority enabled pending flag: done = 1, read = 2, write wanted = 3, underflow = 4, overwrite = 5, none = 0.
- R12: Within a byte, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register index for read and write |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request, level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The bench builds the block with DIV = 2, so a full two-frame read takes only a few hundred cycles. This keeps dozens of random writes and reads, plus the directed flag and priority cases, within a short run. A behavioural device with 256 registers decodes START and STOP edges from the line levels. It drives read data only while SCL is low, so the sampling point of the master and the release of SDA on the ninth bit are both exercised.

// File: rtl/sccb_pkg.sv
package sccb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BYTE,
    ST_STOP,
    ST_GAP
  } seq_state_t;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NFLAG  = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DEV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SUB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd6;
  localparam logic [ADDR_W-1:0] A_VEC  = 3'd7;

  // flag positions, index order is also service priority
  localparam int unsigned FL_DONE = 0;
  localparam int unsigned FL_RXB  = 1;
  localparam int unsigned FL_TXW  = 2;
  localparam int unsigned FL_UDF  = 3;
  localparam int unsigned FL_OVR  = 4;
endpackage

// File: rtl/sccb_tick.sv
module sccb_tick #(
  parameter int unsigned DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = run;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      assign tick = run && (cnt == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sccb_seq.sv
module sccb_seq
  import sccb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       launch,
  input  logic       launch_dir,
  input  logic [6:0] dev_id,
  input  logic [7:0] sub,
  input  logic [7:0] tx_data,
  input  logic       tx_full,
  input  logic       sda_in,
  output logic       busy,
  output logic       in_byte,
  output logic       tx_take,
  output logic       done,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       scl_oe,
  output logic       sda_oe
);
  seq_state_t state;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [1:0] ph;
  logic       pass2;
  logic       dir_wr;
  logic [7:0] sh;
  logic [7:0] rx;
  logic       scl_c, sda_c;
  logic       last_q, rx_ph, bit_lvl, phase_end;

  assign last_q    = tick && (q == 2'd3);
  assign rx_ph     = pass2 && (ph == 2'd2);
  assign bit_lvl   = (bitn == 4'd8 || rx_ph) ? 1'b1 : sh[7];
  assign phase_end = (state == ST_BYTE) && last_q && (bitn == 4'd8);
  assign tx_take   = phase_end && (ph == 2'd1) && dir_wr;
  assign done      = (state == ST_STOP) && last_q && (dir_wr || pass2);
  assign rx_valid  = done && !dir_wr;
  assign rx_byte   = rx;
  assign busy      = (state != ST_IDLE);
  assign in_byte   = (state == ST_BYTE);

  always_comb begin
    scl_c = 1'b1;
    sda_c = 1'b1;
    unique case (state)
      ST_START: begin scl_c = (q != 2'd3); sda_c = (q == 2'd0); end
      ST_BYTE:  begin scl_c = (q == 2'd1) || (q == 2'd2); sda_c = bit_lvl; end
      ST_STOP:  begin scl_c = (q != 2'd0); sda_c = q[1]; end
      default:  begin scl_c = 1'b1; sda_c = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      q      <= '0;
      bitn   <= '0;
      ph     <= '0;
      pass2  <= 1'b0;
      dir_wr <= 1'b0;
      sh     <= '0;
      rx     <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= ~scl_c;
      sda_oe <= ~sda_c;
      if (state == ST_IDLE) begin
        if (launch) begin
          state  <= ST_START;
          q      <= '0;
          pass2  <= 1'b0;
          dir_wr <= launch_dir;
        end
      end else if (tick) begin
        q <= q + 1'b1;
        unique case (state)
          ST_START: if (q == 2'd3) begin
            state <= ST_BYTE;
            bitn  <= '0;
            ph    <= 2'd0;
            sh    <= {dev_id, pass2};
          end
          ST_BYTE: begin
            if (q == 2'd1 && rx_ph && bitn != 4'd8) rx <= {rx[6:0], sda_in};
            if (q == 2'd3) begin
              if (bitn == 4'd8) begin
                bitn <= '0;
                unique case (ph)
                  2'd0: begin
                    if (pass2) ph <= 2'd2;
                    else begin ph <= 2'd1; sh <= sub; end
                  end
                  2'd1: begin
                    if (dir_wr) begin
                      ph <= 2'd2;
                      sh <= tx_full ? tx_data : 8'hFF;
                    end else state <= ST_STOP;
                  end
                  default: state <= ST_STOP;
                endcase
              end else begin
                bitn <= bitn + 1'b1;
                sh   <= {sh[6:0], 1'b0};
              end
            end
          end
          ST_STOP: if (q == 2'd3) begin
            if (!dir_wr && !pass2) begin
              state <= ST_GAP;
              pass2 <= 1'b1;
            end else state <= ST_IDLE;
          end
          ST_GAP: if (q == 2'd3) state <= ST_START;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sccb_regs.sv
module sccb_regs
  import sccb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              busy,
  input  logic              tx_take,
  input  logic              done,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              launch,
  output logic              launch_dir,
  output logic [6:0]        dev_id,
  output logic [7:0]        sub,
  output logic [7:0]        tx_data,
  output logic              tx_full,
  output logic [NFLAG-1:0]  flags,
  output logic              irq
);
  logic             dir_q;
  logic [7:0]       rxd_q;
  logic [NFLAG-1:0] ien_q;
  logic [NFLAG-1:0] set_v, clr_v, pend;
  logic [2:0]       vec;
  logic             wr_ctrl;

  assign wr_ctrl    = reg_wr && (reg_addr == A_CTRL);
  assign launch     = wr_ctrl && reg_wdata[0] && !busy;
  assign launch_dir = reg_wdata[1];

  always_comb begin
    set_v         = '0;
    set_v[FL_DONE] = done;
    set_v[FL_RXB]  = rx_valid;
    set_v[FL_TXW]  = launch && reg_wdata[1] && !tx_full;
    set_v[FL_UDF]  = tx_take && !tx_full;
    set_v[FL_OVR]  = rx_valid && flags[FL_RXB];
    clr_v = (reg_wr && reg_addr == A_STAT) ? reg_wdata[NFLAG-1:0] : '0;
  end

  assign pend = flags & ien_q;
  assign irq  = |pend;

  always_comb begin
    vec = 3'd0;
    for (int i = NFLAG - 1; i >= 0; i--) begin
      if (pend[i]) vec = 3'(i + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      dev_id  <= '0;
      sub     <= '0;
      tx_data <= '0;
      tx_full <= 1'b0;
      rxd_q   <= '0;
      ien_q   <= '0;
      flags   <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      if (rx_valid) rxd_q <= rx_byte;
      if (tx_take) tx_full <= 1'b0;
      if (reg_wr) begin
        unique case (reg_addr)
          A_CTRL: dir_q <= reg_wdata[1];
          A_DEV:  dev_id <= reg_wdata[6:0];
          A_SUB:  sub <= reg_wdata;
          A_TXD:  begin tx_data <= reg_wdata; tx_full <= 1'b1; end
          A_IEN:  ien_q <= reg_wdata[NFLAG-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {6'b0, dir_q, 1'b0};
      A_DEV:   reg_rdata = {1'b0, dev_id};
      A_SUB:   reg_rdata = sub;
      A_TXD:   reg_rdata = tx_data;
      A_RXD:   reg_rdata = rxd_q;
      A_STAT:  reg_rdata = {busy, 2'b0, flags};
      A_IEN:   reg_rdata = {3'b0, ien_q};
      default: reg_rdata = {5'b0, vec};
    endcase
  end
endmodule

// File: rtl/sccb_master.sv
module sccb_master
  import sccb_pkg::*;
#(
  parameter int unsigned DIV = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic             busy_w, in_byte_w, tick_w, launch_w, launch_dir_w;
  logic             tx_take_w, done_w, rx_valid_w, tx_full_w;
  logic [7:0]       rx_byte_w, sub_w, tx_data_w;
  logic [6:0]       dev_w;
  logic [NFLAG-1:0] flags_w;

  sccb_tick #(.DIV(DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .tick(tick_w)
  );

  sccb_regs regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy_w), .tx_take(tx_take_w), .done(done_w),
    .rx_valid(rx_valid_w), .rx_byte(rx_byte_w),
    .launch(launch_w), .launch_dir(launch_dir_w),
    .dev_id(dev_w), .sub(sub_w), .tx_data(tx_data_w), .tx_full(tx_full_w),
    .flags(flags_w), .irq(irq)
  );

  sccb_seq seq_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_w),
    .launch(launch_w), .launch_dir(launch_dir_w),
    .dev_id(dev_w), .sub(sub_w), .tx_data(tx_data_w), .tx_full(tx_full_w),
    .sda_in(sda_in),
    .busy(busy_w), .in_byte(in_byte_w), .tx_take(tx_take_w), .done(done_w),
    .rx_valid(rx_valid_w), .rx_byte(rx_byte_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/sccb_master_chk.sv
module sccb_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       launch,
  input logic       done,
  input logic       in_byte,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [4:0] flags,
  input logic       irq
);
  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R5
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R5
  AST_LINES_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R5
  AST_DONE_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flags[0]); // R7
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe)); // R12
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 5'd0)); // R11
endmodule

bind sccb_master sccb_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .launch(launch_w), .done(done_w),
  .in_byte(in_byte_w), .scl_oe(scl_oe), .sda_oe(sda_oe), .flags(flags_w), .irq(irq)
);

// File: tb/sccb_master_tb_top.sv
module sccb_master_tb_top;
  localparam int DIV = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe, sda_in;
  logic slv_low = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_low);
  assign sda_in = sda_line;

  sccb_master #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  // behavioural camera device, 256 registers
  logic [7:0] dev_mem [256];
  logic [7:0] exp_mem [256];
  logic p_scl = 1'b1, p_sda = 1'b1, rw = 1'b0;
  logic [7:0] shin = '0, ptr = '0, rdbyte = '0, id_seen = '0;
  int starts = 0, stops = 0, rises = 0, byte_idx = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = 8'(i * 37 + 11);
      exp_mem[i] = 8'(i * 37 + 11);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_scl && scl_line && p_sda && !sda_line) begin
        starts++; byte_idx = 0; rises = 0; rw = 1'b0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        stops++;
      end else if (!p_scl && scl_line) begin
        if (rises < 8) shin = {shin[6:0], sda_line};
        rises++;
        if (rises == 9) begin
          if (byte_idx == 0) begin
            id_seen = shin; rw = shin[0];
            if (rw) rdbyte = dev_mem[ptr];
          end else if (!rw && byte_idx == 1) ptr = shin;
          else if (!rw && byte_idx == 2) dev_mem[ptr] = shin;
          byte_idx++; rises = 0;
        end
      end else if (p_scl && !scl_line) begin
        slv_low = rw && byte_idx == 1 && rises < 8 && !rdbyte[7 - rises];
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin rd(3'd5, s); n++; end while (s[7] && n < 20000);
    if (n >= 20000) chk("R5 busy never cleared", 1, 0);
  endtask

  function automatic logic [7:0] id_byte(input logic [6:0] id, input logic r);
    return {id, r};
  endfunction

  task automatic do_write(input logic [6:0] id, input logic [7:0] sub, input logic [7:0] d);
    int s0;
    s0 = starts;
    wr(3'd1, {1'b0, id}); wr(3'd2, sub); wr(3'd3, d);
    wr(3'd0, 8'h03); wait_idle();
    exp_mem[sub] = d;
    chk("R2 device register written", dev_mem[sub], exp_mem[sub]);
    chk("R2 id byte", id_seen, id_byte(id, 1'b0));
    chk("R2 one start per write", starts - s0, 1);
  endtask

  task automatic do_read(input logic [6:0] id, input logic [7:0] sub, output logic [7:0] v);
    int s0, p0;
    s0 = starts; p0 = stops;
    wr(3'd1, {1'b0, id}); wr(3'd2, sub);
    wr(3'd0, 8'h01); wait_idle();
    rd(3'd4, v);
    chk("R3 read data", v, exp_mem[sub]);
    chk("R3 two starts", starts - s0, 2);
    chk("R3 two stops", stops - p0, 2);
    chk("R3 id byte read bit", id_seen, id_byte(id, 1'b1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s0, p0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd5, v); chk("R1 status after reset", v, 8'h00);
    rd(3'd7, v); chk("R1 vector after reset", v, 8'h00);
    chk("R1 irq after reset", irq, 0);
    chk("R1 lines released", {scl_oe, sda_oe}, 2'b00);

    p0 = stops;
    do_write(7'h21, 8'h10, 8'hA5);
    chk("R2 one stop per write", stops - p0, 1);
    rd(3'd5, v); chk("R7 R9 done only, preloaded byte", v, 8'h01);
    chk("R5 lines released when idle", {scl_oe, sda_oe}, 2'b00);

    wr(3'd5, 8'h00); rd(3'd5, v); chk("R10 write 0 keeps flag", v, 8'h01);
    wr(3'd5, 8'h01); rd(3'd5, v); chk("R10 write 1 clears flag", v, 8'h00);

    do_read(7'h21, 8'h10, v);
    rd(3'd5, v); chk("R7 R8 done and read flags", v, 8'h03);
    do_read(7'h3C, 8'h33, v);
    rd(3'd5, v); chk("R8 overwrite flag", v, 8'h13);
    wr(3'd5, 8'h1F);

    // busy, go and stop while busy
    s0 = starts; p0 = stops;
    wr(3'd1, 8'h05); wr(3'd2, 8'h44); wr(3'd3, 8'h5E);
    wr(3'd0, 8'h03);
    rd(3'd5, v); chk("R5 busy during transfer", v[7], 1);
    wr(3'd0, 8'h07);
    wait_idle();
    exp_mem[8'h44] = 8'h5E;
    chk("R4 go while busy ignored", starts - s0, 1);
    chk("R6 stop request ignored", stops - p0, 1);
    chk("R6 data byte still delivered", dev_mem[8'h44], 8'h5E);
    s0 = starts;
    wr(3'd0, 8'h04); repeat (20) @(negedge clk);
    rd(3'd5, v);
    chk("R6 stop alone starts nothing", starts - s0, 0);
    chk("R6 stop alone leaves idle", v[7], 0);
    wr(3'd5, 8'h1F);

    // underflow: no data loaded
    wr(3'd2, 8'h77); wr(3'd0, 8'h03);
    rd(3'd5, v); chk("R9 write byte wanted at launch", v[2], 1);
    wait_idle();
    exp_mem[8'h77] = 8'hFF;
    rd(3'd5, v); chk("R9 underflow flags", v, 8'h0D);
    chk("R9 0xFF sent on underflow", dev_mem[8'h77], 8'hFF);

    chk("R11 irq masked", irq, 0);
    wr(3'd6, 8'h1F); @(negedge clk);
    chk("R11 irq enabled", irq, 1);
    rd(3'd7, v); chk("R11 vector done first", v, 3'd1);
    wr(3'd5, 8'h01); rd(3'd7, v); chk("R11 vector write wanted", v, 3'd3);
    wr(3'd5, 8'h04); rd(3'd7, v); chk("R11 vector underflow", v, 3'd4);
    wr(3'd6, 8'h10); @(negedge clk);
    chk("R11 irq off with only other enables", irq, 0);
    rd(3'd7, v); chk("R11 vector none", v, 3'd0);
    wr(3'd6, 8'h00); wr(3'd5, 8'h1F);

    for (int k = 0; k < 24; k++) begin
      logic [6:0] id;
      logic [7:0] sb, dd;
      id = 7'($urandom); sb = 8'($urandom); dd = 8'($urandom);
      if ($urandom % 2) do_write(id, sb, dd);
      else do_read(id, sb, v);
      wr(3'd5, 8'h1F);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule